// File: doc/BRIEF.md
# Signal-detect qualifier with scrambling control register

This block sits between a raw signal-detect input from the optical or line receiver and the downstream link logic. It holds one 16-bit control register that a host reads and writes over a simple strobe-and-address interface. The register turns scrambling on or off and requests a scrambler-to-descrambler loopback. It also chooses two optional hold-off delays. One delay applies to the rising edge of signal-detect and one to its falling edge.

Scrambling is active when a hardware strap input is high or when the software enable bit is set. The strap also forces that bit to 1. While scrambling is active and an edge's delay is enabled, the qualified output follows a change of the raw input only after the raw level has stayed put for the selected number of time-base ticks. The rising-edge delay gives the descrambler time to lock before the link is told a signal is present. In every other case the raw level reaches the output through a single register stage. The tick is a one-cycle strobe from an external time base, and each tick stands for 0.01 time units.

Top module: `sigdet_qual`

## Requirements
- R1: The register answers only at address 0xA. rd_data is registered: the cycle after `addr` is presented, it shows the register view for 0xA and 0 for every other address. Writes (wr_en high) to any other address change nothing.
- R2: Field layout: bit 0 cipher enable, bit 1 loopback, bit 6 deassert-delay enable, bit 7 assert-delay enable, bits 11:10 assert-delay select, bits 13:12 deassert-delay select. Bits 15:14, 9:8 and 5:2 always read 0, whatever was written.
- R3: Output `loop_en` equals register bit 1 from the cycle after the write.
- R4: While rst_n is low (synchronous), bits 15:1 clear to 0 and bit 0 takes the level of `strap_scr`. `sd_qual` resets to 0.
- R5: While `strap_scr` is high, bit 0 reads 1 and a write of 0 to it is ignored. Once the strap falls, the bit keeps 1 until software writes it. With the strap low, the bit holds the written value. `scr_active` is high when the strap or bit 0 is high.
- R6: When scrambling is inactive, or when the delay for the edge in question is disabled, `sd_qual` takes the `sd_raw` level one clock after it changes.
- R7: With scrambling active and bit 7 set, a rise of `sd_raw` reaches `sd_qual` at the clock edge of the Nth tick seen while `sd_raw` stays high. N is 84, 132, 252 or 512 for select 00, 01, 10, 11. Without ticks, `sd_qual` does not rise.
- R8: With scrambling active and bit 6 set, a fall of `sd_raw` reaches `sd_qual` at the Nth tick seen while `sd_raw` stays low. N is 76, 132, 252 or 512 for select 00, 01, 10, 11. Without ticks, `sd_qual` does not fall.
- R9: If `sd_raw` returns to the `sd_qual` level before the count completes, the count is discarded. The next change needs the full N ticks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_scr | input | 1 | Hardware scrambling strap |
| wr_en | input | 1 | Host write strobe |
| addr | input | 4 | Host register address |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Registered read data for the address of the previous cycle |
| tick | input | 1 | Single-cycle time-base strobe, one per 0.01 time unit |
| sd_raw | input | 1 | Unqualified signal-detect, synchronous to clk |
| sd_qual | output | 1 | Qualified signal-detect |
| loop_en | output | 1 | Scrambler-to-descrambler loopback request |
| scr_active | output | 1 | Scrambling function active |

## Verification
The assertions assume `sd_raw`, `tick` and the host inputs are already synchronous to `clk` and stable around the edge. The hold-off checks also assume that a cycle without a tick cannot complete a count. The bench drives every input at the falling edge, so these assumptions hold. It raises `tick` only through its own period setting and changes the configuration only while the output and raw levels agree. Random register traffic uses all 16 addresses and arbitrary data, and it toggles the strap between accesses.

// File: rtl/sigdet_pkg.sv
package sigdet_pkg;

   // Register field positions (the layout that software decodes)
   localparam int unsigned F_CIPHER  = 0;
   localparam int unsigned F_LOOP    = 1;
   localparam int unsigned F_OFF_EN  = 6;
   localparam int unsigned F_ON_EN   = 7;
   localparam int unsigned F_ON_LSB  = 10;
   localparam int unsigned F_OFF_LSB = 12;

   // Bits 15:1 that hold software state; everything else reads 0
   localparam logic [15:0] RW_MASK = 16'h3CC2;

   typedef struct packed {
      logic [1:0] off_sel;
      logic [1:0] on_sel;
      logic       on_en;
      logic       off_en;
      logic       loop;
      logic       cipher;
   } sd_ctrl_t;

   // Edge direction used to index the per-edge timers
   localparam int unsigned DIR_FALL = 0;
   localparam int unsigned DIR_RISE = 1;

endpackage

// File: rtl/sigdet_ctrl_reg.sv
module sigdet_ctrl_reg
   import sigdet_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 16,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'hA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_scr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output sd_ctrl_t          ctrl,
   output logic              scr_active
);

   localparam logic [DATA_W-1:0] MASK_W = DATA_W'(RW_MASK);

   logic [DATA_W-1:1] reg_q;
   logic              cip_q;
   logic              hit;
   logic [DATA_W-1:0] view;

   assign hit = (addr == REG_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q <= '0;
      end else if (wr_en && hit) begin
         reg_q <= wr_data[DATA_W-1:1] & MASK_W[DATA_W-1:1];
      end
   end

   // Cipher enable: reset loads the strap, strap forces 1, else software
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cip_q <= strap_scr;
      end else if (strap_scr) begin
         cip_q <= 1'b1;
      end else if (wr_en && hit) begin
         cip_q <= wr_data[F_CIPHER];
      end
   end

   assign scr_active = cip_q | strap_scr;
   assign view       = {reg_q, scr_active};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else begin
         rd_data <= hit ? view : '0;
      end
   end

   assign ctrl.off_sel = reg_q[F_OFF_LSB+1:F_OFF_LSB];
   assign ctrl.on_sel  = reg_q[F_ON_LSB+1:F_ON_LSB];
   assign ctrl.on_en   = reg_q[F_ON_EN];
   assign ctrl.off_en  = reg_q[F_OFF_EN];
   assign ctrl.loop    = reg_q[F_LOOP];
   assign ctrl.cipher  = cip_q;

endmodule

// File: rtl/sigdet_edge_timer.sv
module sigdet_edge_timer #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   assign cnt_nxt = cnt_q + 1'b1;
   assign done    = arm && tick && (cnt_nxt >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n || !arm || done) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_nxt;
      end
   end

endmodule

// File: rtl/sigdet_filter.sv
module sigdet_filter
   import sigdet_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             sd_raw,
   input  logic [1:0]       dly_en,
   input  logic [CNT_W-1:0] lim_fall,
   input  logic [CNT_W-1:0] lim_rise,
   output logic             sd_qual
);

   logic             sd_q;
   logic             differs;
   logic [1:0]       done;
   logic [CNT_W-1:0] lim [2];

   assign lim[DIR_FALL] = lim_fall;
   assign lim[DIR_RISE] = lim_rise;
   assign differs       = (sd_raw != sd_q);

   for (genvar d = 0; d < 2; d++) begin : g_dir
      logic arm_d;
      assign arm_d = differs && (sd_raw == 1'(d)) && dly_en[d];
      sigdet_edge_timer #(.CNT_W(CNT_W)) u_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .arm   (arm_d),
         .tick  (tick),
         .limit (lim[d]),
         .done  (done[d])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sd_q <= 1'b0;
      end else if (differs && (!dly_en[sd_raw] || done[sd_raw])) begin
         sd_q <= sd_raw;
      end
   end

   assign sd_qual = sd_q;

endmodule

// File: rtl/sigdet_qual.sv
module sigdet_qual
   import sigdet_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 16,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'hA,
   parameter int unsigned CNT_W    = 10,
   parameter int unsigned ON_TICKS  [4] = '{84, 132, 252, 512},
   parameter int unsigned OFF_TICKS [4] = '{76, 132, 252, 512}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_scr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              tick,
   input  logic              sd_raw,
   output logic              sd_qual,
   output logic              loop_en,
   output logic              scr_active
);

   localparam longint unsigned CNT_MAX = (64'd1 << CNT_W) - 1;

   if (DATA_W != 16) begin : g_bad_data_w
      $error("sigdet_qual: DATA_W must be 16");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("sigdet_qual: ADDR_W must be at least 1");
   end
   for (genvar i = 0; i < 4; i++) begin : g_lim_chk
      if (ON_TICKS[i] == 0 || ON_TICKS[i] > CNT_MAX) begin : g_bad_on
         $error("sigdet_qual: assert delay count out of counter range");
      end
      if (OFF_TICKS[i] == 0 || OFF_TICKS[i] > CNT_MAX) begin : g_bad_off
         $error("sigdet_qual: deassert delay count out of counter range");
      end
   end

   sd_ctrl_t         ctrl;
   logic             on_dly;
   logic             off_dly;
   logic [CNT_W-1:0] lim_rise;
   logic [CNT_W-1:0] lim_fall;

   sigdet_ctrl_reg #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_ADDR (REG_ADDR)
   ) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_scr  (strap_scr),
      .wr_en      (wr_en),
      .addr       (addr),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .ctrl       (ctrl),
      .scr_active (scr_active)
   );

   assign on_dly   = ctrl.on_en  & scr_active;
   assign off_dly  = ctrl.off_en & scr_active;
   assign lim_rise = CNT_W'(ON_TICKS[ctrl.on_sel]);
   assign lim_fall = CNT_W'(OFF_TICKS[ctrl.off_sel]);
   assign loop_en  = ctrl.loop;

   sigdet_filter #(.CNT_W(CNT_W)) u_flt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .sd_raw   (sd_raw),
      .dly_en   ({on_dly, off_dly}),
      .lim_fall (lim_fall),
      .lim_rise (lim_rise),
      .sd_qual  (sd_qual)
   );

endmodule

// File: rtl/sigdet_qual_chk.sv
module sigdet_qual_chk #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 16,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'hA
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strap_scr,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              tick,
   input logic              sd_raw,
   input logic              sd_qual,
   input logic              loop_en,
   input logic              scr_active,
   input logic              on_dly,
   input logic              off_dly
);

   AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != REG_ADDR) |=> (rd_data == '0)); // R1

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[15:14] == 2'b0) && (rd_data[9:8] == 2'b0) && (rd_data[5:2] == 4'b0)); // R2

   AST_LOOP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_ADDR) |=> (loop_en == $past(wr_data[1]))); // R3

   AST_STRAP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_scr && addr == REG_ADDR) |=> (rd_data[0] && scr_active)); // R5

   AST_PASS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ((sd_raw != sd_qual) && !scr_active) |=> (sd_qual == $past(sd_raw))); // R6

   AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (on_dly && sd_raw && !sd_qual && !tick) |=> !sd_qual); // R7

   AST_FALL_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (off_dly && !sd_raw && sd_qual && !tick) |=> sd_qual); // R8

endmodule

bind sigdet_qual sigdet_qual_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .REG_ADDR (REG_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .strap_scr  (strap_scr),
   .wr_en      (wr_en),
   .addr       (addr),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .tick       (tick),
   .sd_raw     (sd_raw),
   .sd_qual    (sd_qual),
   .loop_en    (loop_en),
   .scr_active (scr_active),
   .on_dly     (on_dly),
   .off_dly    (off_dly)
);

// File: tb/sigdet_qual_tb.sv
`timescale 1ns/1ps
module sigdet_qual_tb;

   localparam int unsigned WD_NS = 200000 * 4;
   localparam logic [3:0]  A_REG = 4'hA;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_scr = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = 4'h0;
   logic [15:0] wr_data = 16'h0;
   logic [15:0] rd_data;
   logic        tick = 1'b0;
   logic        sd_raw = 1'b0;
   logic        sd_qual;
   logic        loop_en;
   logic        scr_active;

   int nchk = 0;
   int nfail = 0;
   logic [15:0] m_st = 16'h0;   // bench copy of the stored register bits
   int on_n  [4] = '{84, 132, 252, 512};
   int off_n [4] = '{76, 132, 252, 512};

   always #2 clk = ~clk;

   sigdet_qual u_dut (
      .clk(clk), .rst_n(rst_n), .strap_scr(strap_scr), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .tick(tick),
      .sd_raw(sd_raw), .sd_qual(sd_qual), .loop_en(loop_en),
      .scr_active(scr_active)
   );

   function automatic logic [15:0] exp_view(input logic [15:0] st, input logic s);
      return {2'b00, st[13:10], 2'b00, st[7:6], 4'b0000, st[1], st[0] | s};
   endfunction

   function automatic logic [15:0] cfg_word(input logic [1:0] off_sel, input logic [1:0] on_sel,
                                            input logic on_en, input logic off_en,
                                            input logic lp, input logic cip);
      return {2'b00, off_sel, on_sel, 2'b00, on_en, off_en, 4'b0000, lp, cip};
   endfunction

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a == A_REG) begin
         m_st[15:1] = d[15:1] & 15'h1E61;
         m_st[0]    = strap_scr ? 1'b1 : d[0];
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] v);
      addr = a;
      @(negedge clk);
      v = rd_data;
   endtask

   task automatic set_strap(input logic v);
      strap_scr = v;
      @(negedge clk);
      if (v) m_st[0] = 1'b1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      m_st = {15'h0, strap_scr};
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Drive sd_raw to lvl; tick every 'period' cycles; return ticks and cycles used
   task automatic run_edge(input logic lvl, input int period, output int tk, output int cy);
      tk = 0; cy = 0;
      for (int i = 0; i < 4000; i++) begin
         logic t;
         t = ((i % period) == 0);
         sd_raw = lvl; tick = t;
         @(negedge clk);
         cy++;
         if (t) tk++;
         if (sd_qual == lvl) break;
      end
      tick = 1'b0;
   endtask

   initial begin
      #(WD_NS);
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail + 1, nchk + 1);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int tk, cy;
      void'($urandom(32'h1F2E3D4C));

      // Reset with the strap high
      strap_scr = 1'b1;
      @(negedge clk);
      do_reset();
      rd(A_REG, v);
      chk(v == 16'h0001, "R4 reset view strap high", v, 16'h0001);
      chk(sd_qual == 1'b0 && loop_en == 1'b0, "R4 outputs after reset", {sd_qual, loop_en}, 0);
      chk(scr_active == 1'b1, "R5 active from strap", scr_active, 1);

      // Full write: reserved bits stay zero, bit0 forced by strap
      wr(A_REG, 16'hFFFE);
      rd(A_REG, v);
      chk(v == 16'h3CC3, "R2 reserved bits read zero", v, 16'h3CC3);
      chk(loop_en == 1'b1, "R3 loop_en follows bit1", loop_en, 1);
      wr(A_REG, 16'h0000);
      chk(loop_en == 1'b0, "R3 loop_en cleared", loop_en, 0);

      // Strap falls: bit0 stays 1 until written
      set_strap(1'b0);
      rd(A_REG, v);
      chk(v[0] == 1'b1, "R5 bit0 held after strap low", v[0], 1);
      wr(A_REG, 16'h0000);
      rd(A_REG, v);
      chk(v[0] == 1'b0 && scr_active == 1'b0, "R5 software clear", {v[0], scr_active}, 0);

      // Reset with strap low after software set bit0
      wr(A_REG, 16'h0001);
      do_reset();
      rd(A_REG, v);
      chk(v == 16'h0000, "R4 reset view strap low", v, 0);

      // Pass-through: delays enabled but scrambling inactive
      wr(A_REG, cfg_word(2'b11, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0));
      for (int i = 0; i < 64; i++) begin
         logic r;
         r = 1'($urandom);
         sd_raw = r; tick = 1'($urandom);
         @(negedge clk);
         chk(sd_qual == r, "R6 one-stage pass inactive", sd_qual, r);
      end
      tick = 1'b0;
      sd_raw = 1'b0;
      @(negedge clk);

      // Rising delay, scrambling via strap
      set_strap(1'b1);
      for (int s = 0; s < 4; s++) begin
         wr(A_REG, cfg_word(2'b00, 2'(s), 1'b1, 1'b0, 1'b0, 1'b0));
         run_edge(1'b1, 1, tk, cy);
         chk(cy == on_n[s], "R7 rise cycles tick every clock", cy, on_n[s]);
         sd_raw = 1'b0;
         @(negedge clk);
         chk(sd_qual == 1'b0, "R6 fall passes when fall delay off", sd_qual, 0);
      end
      wr(A_REG, cfg_word(2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0));
      run_edge(1'b1, 3, tk, cy);
      chk(tk == 132, "R7 rise ticks sparse tick", tk, 132);
      chk(cy == 3 * 131 + 1, "R7 rise lands on the tick edge", cy, 3 * 131 + 1);
      sd_raw = 1'b0;
      @(negedge clk);

      // No ticks: the rise never completes
      sd_raw = 1'b1;
      repeat (600) @(negedge clk);
      chk(sd_qual == 1'b0, "R7 held without ticks", sd_qual, 0);
      sd_raw = 1'b0;
      @(negedge clk);

      // Reversal restarts the count
      wr(A_REG, cfg_word(2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0));
      sd_raw = 1'b1; tick = 1'b1;
      repeat (83) @(negedge clk);
      chk(sd_qual == 1'b0, "R7 not yet at 83 ticks", sd_qual, 0);
      sd_raw = 1'b0;
      @(negedge clk);
      chk(sd_qual == 1'b0, "R9 glitch low", sd_qual, 0);
      run_edge(1'b1, 1, tk, cy);
      chk(cy == 84, "R9 full count after reversal", cy, 84);

      // Falling delay, scrambling via soft bit with strap low
      set_strap(1'b0);
      for (int s = 0; s < 4; s++) begin
         wr(A_REG, cfg_word(2'(s), 2'b00, 1'b0, 1'b1, 1'b0, 1'b1));
         sd_raw = 1'b1;
         @(negedge clk);
         chk(sd_qual == 1'b1, "R6 rise passes when rise delay off", sd_qual, 1);
         run_edge(1'b0, 2, tk, cy);
         chk(tk == off_n[s], "R8 fall ticks", tk, off_n[s]);
      end

      // Fall reversal
      wr(A_REG, cfg_word(2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1));
      sd_raw = 1'b1;
      @(negedge clk);
      sd_raw = 1'b0; tick = 1'b1;
      repeat (75) @(negedge clk);
      sd_raw = 1'b1;
      @(negedge clk);
      run_edge(1'b0, 1, tk, cy);
      chk(cy == 76 && sd_qual == 1'b0, "R9 fall restarts", cy, 76);

      // Random register traffic
      for (int i = 0; i < 400; i++) begin
         int op;
         logic [3:0]  a;
         logic [15:0] d;
         op = int'($urandom % 4);
         d  = 16'($urandom);
         a  = 4'($urandom);
         if (a == A_REG) a = 4'hB;
         case (op)
            0: begin
               wr(A_REG, d);
               rd(A_REG, v);
               chk(v == exp_view(m_st, strap_scr), "R2 random write", v, exp_view(m_st, strap_scr));
               chk(loop_en == m_st[1], "R3 random loop", loop_en, m_st[1]);
            end
            1: begin
               wr(a, d);
               rd(A_REG, v);
               chk(v == exp_view(m_st, strap_scr), "R1 foreign write ignored", v, exp_view(m_st, strap_scr));
            end
            2: begin
               rd(a, v);
               chk(v == 16'h0, "R1 foreign read zero", v, 0);
            end
            default: begin
               set_strap(~strap_scr);
               rd(A_REG, v);
               chk(v == exp_view(m_st, strap_scr), "R5 strap toggle view", v, exp_view(m_st, strap_scr));
               chk(scr_active == (strap_scr | m_st[0]), "R5 active level", scr_active, strap_scr | m_st[0]);
            end
         endcase
      end

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule